// File: doc/BRIEF.md
# Synchronization Word Cache for an Atomic Operation Engine

This block is a small, fully associative cache of 64-bit synchronization words placed in front of an atomic read-modify-write engine that sits next to memory. It merges repeated atomic operations on the same variable, such as a barrier counter or a ticket sequencer, so that memory is not visited for every operation. A hit finishes its read-modify-write in a fixed two cycles, however many requesters contend for the same word. The cache may change a cached word without first gaining exclusive ownership of it.

On a miss the cache picks a slot. An empty slot is taken first, and otherwise the least recently used one. If that slot holds a modified word, the cache first writes the word back with a single-word put request to the directory. It then sends a single-word get request, waits for the coherent value, installs it and replays the stalled operation as a hit. New operations are held off while a miss is being serviced.

Top module: `syncword_cache`

## Requirements
- R1: Every accepted operation produces exactly one response. Responses come in acceptance order, and each one carries the value the word held just before that operation.
- R2: An operation that hits raises rsp_valid exactly two rising clock edges after the edge that accepted it, and it causes no directory request.
- R3: A miss issues one get request (dir_req_is_put = 0) whose address is the request address with its three low bits cleared. A directory request stays asserted with a stable address until dir_req_ready is seen.
- R4: Operation codes are 0 = read (word unchanged), 1 = increment by one, 2 = add req_operand (modulo 2^64) and 3 = swap in req_operand. The new value is kept in the cache and later operations see it.
- R5: Up to eight distinct words are held at once. After eight different words have been brought in, further operations on any of them cause no directory traffic.
- R6: When all eight slots are valid, a miss replaces the least recently used slot. Both a hit and a fill count as a use.
- R7: When the replaced slot has been changed by an increment, add or swap since it was filled, a put request carrying that slot's word address and current value is accepted before the get request for the new word.
- R8: When the replaced slot has only been read since its fill, no put request is issued.
- R9: While a miss is being serviced, req_ready is low and no new operation is accepted.
- R10: The three low bits of req_addr are ignored. Byte addresses inside the same aligned 8-byte word use the same slot.
- R11: After reset, req_ready is high, rsp_valid and dir_req_valid are low, and the cache is empty, so the first access to any word misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Operation request from the engine |
| req_ready | output | 1 | Cache can accept an operation this cycle |
| req_op | input | 2 | Operation code: 0 read, 1 increment, 2 add, 3 swap |
| req_addr | input | 32 | Byte address of the synchronization word |
| req_operand | input | 64 | Addend or swap value |
| rsp_valid | output | 1 | Response strobe, one cycle per operation |
| rsp_data | output | 64 | Value of the word before the operation |
| dir_req_valid | output | 1 | Request to the directory |
| dir_req_ready | input | 1 | Directory takes the request |
| dir_req_is_put | output | 1 | 1 = put (write-back), 0 = get (fetch) |
| dir_req_addr | output | 32 | Word-aligned byte address of the request |
| dir_req_data | output | 64 | Write-back value for a put |
| dir_rsp_valid | input | 1 | Coherent value for the outstanding get |
| dir_rsp_data | input | 64 | Fetched word value |

## Verification
A hit is due two edges after its accepting edge. The bench counts falling edges from the first falling edge after acceptance and expects rsp_valid on the second, while the directory counters must stay unchanged. A miss has no fixed latency because the directory model answers three cycles after it sees the get. For misses the bench waits for rsp_valid, checks that the latency is above two, and checks that req_ready was low at every falling edge where a directory request was visible. Responses are compared with a bench-side memory image that applies each operation in order, and write-back data is compared with the same image when the put is seen.

// File: rtl/syncword_pkg.sv
package syncword_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_INC  = 2'd1,
    OP_ADD  = 2'd2,
    OP_SWAP = 2'd3
  } sw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUT  = 2'd1,
    ST_GET  = 2'd2,
    ST_WAIT = 2'd3
  } sw_state_e;

endpackage

// File: rtl/syncword_rst_sync.sv
module syncword_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/syncword_store.sv
module syncword_store #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [ENTRIES-1:0] match,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [DATA_W-1:0] hit_data,
  output logic              hit_dirty,
  // free slot search
  output logic              free_any,
  output logic [IDX_W-1:0]  free_idx,
  // indexed read
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dirty,
  output logic              rd_valid,
  // write
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] drt_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we  = wr_en && (wr_idx == IDX_W'(g));
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        drt_q[g] <= 1'b0;
      end else if (slot_we) begin
        vld_q[g] <= 1'b1;
        drt_q[g] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_data  = data_q[hit_idx];
  assign hit_dirty = drt_q[hit_idx];
  assign free_any  = ~&vld_q;

  assign rd_tag    = tag_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign rd_dirty  = drt_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];

endmodule

// File: rtl/syncword_lru.sv
module syncword_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    logic [IDX_W-1:0] age_d;
    always_comb begin
      age_d = age_q[g];
      if (touch_idx == IDX_W'(g)) begin
        age_d = '0;
      end else if (age_q[g] < touched_age) begin
        age_d = age_q[g] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_en) begin
        age_q[g] <= age_d;
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == IDX_W'(ENTRIES - 1)) lru_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/syncword_alu.sv
module syncword_alu
  import syncword_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  sw_op_e            op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val,
  output logic              modifies
);

  always_comb begin
    new_val  = old_val;
    modifies = 1'b1;
    case (op)
      OP_READ: modifies = 1'b0;
      OP_INC:  new_val  = old_val + DATA_W'(1);
      OP_ADD:  new_val  = old_val + operand;
      OP_SWAP: new_val  = operand;
      default: modifies = 1'b0;
    endcase
  end

endmodule

// File: rtl/syncword_cache.sv
module syncword_cache
  import syncword_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              dir_req_valid,
  input  logic              dir_req_ready,
  output logic              dir_req_is_put,
  output logic [ADDR_W-1:0] dir_req_addr,
  output logic [DATA_W-1:0] dir_req_data,
  input  logic              dir_rsp_valid,
  input  logic [DATA_W-1:0] dir_rsp_data
);

  localparam int OFS_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic rst_i_n;

  syncword_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // registers
  sw_state_e         state_q, state_d;
  logic              s1_vld_q, s1_vld_d;
  sw_op_e            s1_op_q, s1_op_d;
  logic [TAG_W-1:0]  s1_tag_q, s1_tag_d;
  logic [DATA_W-1:0] s1_opnd_q, s1_opnd_d;
  logic [IDX_W-1:0]  vic_q, vic_d;
  logic              rsp_vld_q, rsp_vld_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  // store and replacement signals
  logic [ENTRIES-1:0] hit_vec;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [DATA_W-1:0] hit_data;
  logic              hit_dirty;
  logic              free_any;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              rd_dirty;
  logic              rd_valid;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              wr_dirty;
  logic [IDX_W-1:0]  lru_idx;
  logic [IDX_W-1:0]  chosen_idx;
  logic [DATA_W-1:0] alu_new;
  logic              alu_mod;

  logic idle, do_hit, do_miss, fill, accept;
  logic unused_ofs;

  assign unused_ofs = ^req_addr[OFS_W-1:0];

  assign idle      = (state_q == ST_IDLE);
  assign do_hit    = idle && s1_vld_q && hit;
  assign do_miss   = idle && s1_vld_q && !hit;
  assign fill      = (state_q == ST_WAIT) && dir_rsp_valid;
  assign req_ready = rst_i_n && idle && (!s1_vld_q || hit);
  assign accept    = req_valid && req_ready;

  assign chosen_idx = free_any ? free_idx : lru_idx;
  assign rd_idx     = idle ? chosen_idx : vic_q;

  syncword_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .lk_tag    (s1_tag_q),
    .match     (hit_vec),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_data  (hit_data),
    .hit_dirty (hit_dirty),
    .free_any  (free_any),
    .free_idx  (free_idx),
    .rd_idx    (rd_idx),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data),
    .rd_dirty  (rd_dirty),
    .rd_valid  (rd_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (s1_tag_q),
    .wr_data   (wr_data),
    .wr_dirty  (wr_dirty)
  );

  syncword_lru #(
    .ENTRIES (ENTRIES)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .touch_en  (wr_en),
    .touch_idx (wr_idx),
    .lru_idx   (lru_idx)
  );

  syncword_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op       (s1_op_q),
    .old_val  (hit_data),
    .operand  (s1_opnd_q),
    .new_val  (alu_new),
    .modifies (alu_mod)
  );

  // store write port: hit update or fill install
  assign wr_en    = do_hit || fill;
  assign wr_idx   = fill ? vic_q : hit_idx;
  assign wr_data  = fill ? dir_rsp_data : alu_new;
  assign wr_dirty = fill ? 1'b0 : (hit_dirty || alu_mod);

  // directory request
  assign dir_req_valid  = (state_q == ST_PUT) || (state_q == ST_GET);
  assign dir_req_is_put = (state_q == ST_PUT);
  assign dir_req_addr   = (state_q == ST_PUT) ? {rd_tag, {OFS_W{1'b0}}}
                                              : {s1_tag_q, {OFS_W{1'b0}}};
  assign dir_req_data   = rd_data;

  assign rsp_valid = rsp_vld_q;
  assign rsp_data  = rsp_data_q;

  // next state
  always_comb begin
    state_d    = state_q;
    vic_d      = vic_q;
    s1_vld_d   = s1_vld_q;
    s1_op_d    = s1_op_q;
    s1_tag_d   = s1_tag_q;
    s1_opnd_d  = s1_opnd_q;
    rsp_vld_d  = do_hit;
    rsp_data_d = rsp_data_q;

    if (do_hit) begin
      rsp_data_d = hit_data;
    end

    if (accept) begin
      s1_vld_d  = 1'b1;
      s1_op_d   = sw_op_e'(req_op);
      s1_tag_d  = req_addr[ADDR_W-1:OFS_W];
      s1_opnd_d = req_operand;
    end else if (do_hit) begin
      s1_vld_d  = 1'b0;
    end

    case (state_q)
      ST_IDLE: begin
        if (do_miss) begin
          vic_d   = chosen_idx;
          state_d = (rd_valid && rd_dirty) ? ST_PUT : ST_GET;
        end
      end
      ST_PUT: begin
        if (dir_req_ready) state_d = ST_GET;
      end
      ST_GET: begin
        if (dir_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (dir_rsp_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      s1_vld_q  <= 1'b0;
      rsp_vld_q <= 1'b0;
      vic_q     <= '0;
    end else begin
      state_q   <= state_d;
      s1_vld_q  <= s1_vld_d;
      rsp_vld_q <= rsp_vld_d;
      vic_q     <= vic_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      s1_op_q   <= s1_op_d;
      s1_tag_q  <= s1_tag_d;
      s1_opnd_q <= s1_opnd_d;
    end
    if (do_hit) begin
      rsp_data_q <= rsp_data_d;
    end
  end

endmodule

// File: rtl/syncword_cache_chk.sv
module syncword_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               dir_req_valid,
  input logic               dir_req_ready,
  input logic               dir_req_is_put,
  input logic [ADDR_W-1:0]  dir_req_addr,
  input logic [ENTRIES-1:0] hit_vec
);

  logic [1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 2'd0;
    end else begin
      outst_q <= outst_q + 2'((req_valid && req_ready) ? 1 : 0)
                         - 2'(rsp_valid ? 1 : 0);
    end
  end

  // R1: a response only for an operation that is still open
  assert_rsp_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (outst_q != 2'd0));

  // R1: never more than two operations in flight
  assert_inflight_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= 2'd2);

  // R3: directory request held stable until taken
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req_valid && !dir_req_ready) |=>
      (dir_req_valid && $stable(dir_req_addr) && $stable(dir_req_is_put)));

  // R5: a word occupies at most one slot
  assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7: an accepted write-back is followed by the fetch
  assert_put_then_get_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req_valid && dir_req_is_put && dir_req_ready) |=>
      (dir_req_valid && !dir_req_is_put));

  // R9: no acceptance while the directory is being asked
  assert_stall_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |-> !req_ready);

endmodule

bind syncword_cache syncword_cache_chk #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .dir_req_valid  (dir_req_valid),
  .dir_req_ready  (dir_req_ready),
  .dir_req_is_put (dir_req_is_put),
  .dir_req_addr   (dir_req_addr),
  .hit_vec        (hit_vec)
);

// File: tb/syncword_cache_bench.sv
`timescale 1ns/1ps
module syncword_cache_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_operand;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              dir_req_valid;
  logic              dir_req_ready;
  logic              dir_req_is_put;
  logic [ADDR_W-1:0] dir_req_addr;
  logic [DATA_W-1:0] dir_req_data;
  logic              dir_rsp_valid;
  logic [DATA_W-1:0] dir_rsp_data;

  syncword_cache u_syncword_cache (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_op         (req_op),
    .req_addr       (req_addr),
    .req_operand    (req_operand),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .dir_req_valid  (dir_req_valid),
    .dir_req_ready  (dir_req_ready),
    .dir_req_is_put (dir_req_is_put),
    .dir_req_addr   (dir_req_addr),
    .dir_req_data   (dir_req_data),
    .dir_rsp_valid  (dir_rsp_valid),
    .dir_rsp_data   (dir_rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [DATA_W-1:0] dmem [256];
  logic [DATA_W-1:0] gmem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int get_cnt = 0;
  int put_cnt = 0;
  int seq     = 0;
  int last_put_seq, last_get_seq;
  logic [ADDR_W-1:0] last_put_addr, last_get_addr;
  logic [DATA_W-1:0] last_put_data;
  int bad_ready = 0;
  int stall_n   = 0;
  int last_lat  = 0;
  bit done      = 0;

  function automatic logic [ADDR_W-1:0] waddr(input int i);
    return ADDR_W'(32'h100 + i * 8);
  endfunction

  function automatic logic [DATA_W-1:0] init_val(input int i);
    return 64'h0123_0000_0000_0000 ^ (64'(i) * 64'h1111);
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // directory model: always ready, answers a get three cycles after seeing it
  initial begin : dir_model
    int cnt;
    int pidx;
    bit pend;
    pend = 0;
    cnt = 0;
    pidx = 0;
    dir_req_ready = 1'b1;
    dir_rsp_valid = 1'b0;
    dir_rsp_data  = '0;
    forever begin
      @(negedge clk);
      dir_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          dir_rsp_valid = 1'b1;
          dir_rsp_data  = dmem[pidx];
          pend = 0;
        end else begin
          cnt--;
        end
      end
      if (rst_n && dir_req_valid) begin
        seq++;
        if (req_ready) bad_ready++;
        if (dir_req_is_put) begin
          put_cnt++;
          last_put_seq  = seq;
          last_put_addr = dir_req_addr;
          last_put_data = dir_req_data;
          dmem[dir_req_addr[10:3]] = dir_req_data;
        end else begin
          get_cnt++;
          last_get_seq  = seq;
          last_get_addr = dir_req_addr;
          pidx = int'(dir_req_addr[10:3]);
          cnt  = 2;
          pend = 1;
        end
      end
    end
  end

  task automatic do_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = '0;
    req_addr  = '0;
    req_operand = '0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = init_val(i);
      gmem[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one operation; checks the response against the bench memory image (R1)
  task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] opnd);
    int idx;
    logic [DATA_W-1:0] old_v, new_v;
    @(negedge clk);
    req_valid   = 1'b1;
    req_op      = op;
    req_addr    = addr;
    req_operand = opnd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_lat  = 1;
    while (!rsp_valid) begin
      if (!req_ready) stall_n++;
      @(negedge clk);
      last_lat++;
    end
    idx   = int'(addr[10:3]);
    old_v = gmem[idx];
    case (op)
      2'd0: new_v = old_v;
      2'd1: new_v = old_v + 64'd1;
      2'd2: new_v = old_v + opnd;
      default: new_v = opnd;
    endcase
    gmem[idx] = new_v;
    check("R1 response old value", rsp_data, old_v);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 req_ready after reset", 64'(req_ready), 64'd1);
    check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R11 dir_req_valid after reset", 64'(dir_req_valid), 64'd0);
    do_op(2'd0, waddr(5), '0);
    check("R11 first access misses", 64'(get_cnt), 64'd1);
  endtask

  task automatic t_miss();
    int g0;
    do_reset();
    g0 = get_cnt;
    stall_n = 0;
    bad_ready = 0;
    do_op(2'd1, waddr(2) + 3, '0);
    check("R3 one get per miss", 64'(get_cnt - g0), 64'd1);
    check("R3 get address aligned", 64'(last_get_addr), 64'(waddr(2)));
    check("R3 miss latency above two", 64'(last_lat > 2), 64'd1);
    check("R9 ready low during miss", 64'(stall_n > 0), 64'd1);
    check("R9 no ready while dir busy", 64'(bad_ready), 64'd0);
  endtask

  task automatic t_hit_latency();
    int g0, p0;
    g0 = get_cnt;
    p0 = put_cnt;
    for (int k = 0; k < 4; k++) begin
      do_op(2'd2, waddr(2), 64'(k + 10));
      check("R2 hit latency two edges", 64'(last_lat), 64'd2);
    end
    check("R2 no directory traffic on hits", 64'((get_cnt - g0) + (put_cnt - p0)), 64'd0);
  endtask

  task automatic t_ops();
    int g0;
    do_reset();
    do_op(2'd0, waddr(7), '0);
    g0 = get_cnt;
    do_op(2'd1, waddr(7), 64'hdead);
    do_op(2'd2, waddr(7), 64'hffff_ffff_ffff_fff0);
    do_op(2'd3, waddr(7), 64'h5555_aaaa_0000_1234);
    do_op(2'd0, waddr(7), '0);
    do_op(2'd2, waddr(7), 64'd1);
    do_op(2'd0, waddr(7), '0);
    check("R4 ops served in cache", 64'(get_cnt - g0), 64'd0);
    check("R4 swap then add stored", rsp_data, 64'h5555_aaaa_0000_1235);
  endtask

  task automatic t_capacity();
    int g0;
    do_reset();
    for (int i = 0; i < 8; i++) do_op(2'd0, waddr(i), '0);
    g0 = get_cnt;
    for (int i = 7; i >= 0; i--) do_op(2'd1, waddr(i), '0);
    check("R5 eight words resident", 64'(get_cnt - g0), 64'd0);
  endtask

  task automatic t_lru_dirty();
    int g0, p0;
    do_reset();
    for (int i = 0; i < 8; i++) do_op(2'd1, waddr(i), '0);
    do_op(2'd0, waddr(0), '0);
    p0 = put_cnt;
    g0 = get_cnt;
    do_op(2'd1, waddr(8), '0);
    check("R7 one put for dirty victim", 64'(put_cnt - p0), 64'd1);
    check("R6 victim is least recent", 64'(last_put_addr), 64'(waddr(1)));
    check("R7 put data current", last_put_data, gmem[33]);
    check("R7 put before get", 64'(last_put_seq < last_get_seq), 64'd1);
    check("R7 get for new word", 64'(last_get_addr), 64'(waddr(8)));
    g0 = get_cnt;
    do_op(2'd0, waddr(0), '0);
    for (int i = 2; i < 8; i++) do_op(2'd0, waddr(i), '0);
    check("R6 survivors still hit", 64'(get_cnt - g0), 64'd0);
    p0 = put_cnt;
    do_op(2'd0, waddr(1), '0);
    check("R6 fill counts as use", 64'(last_put_addr), 64'(waddr(8)));
    check("R7 second eviction puts", 64'(put_cnt - p0), 64'd1);
    check("R1 evicted word refetched", rsp_data, gmem[33]);
  endtask

  task automatic t_clean();
    int g0, p0;
    do_reset();
    g0 = get_cnt;
    p0 = put_cnt;
    for (int i = 0; i < 9; i++) do_op(2'd0, waddr(i), '0);
    check("R8 clean victim no put", 64'(put_cnt - p0), 64'd0);
    check("R8 nine fetches", 64'(get_cnt - g0), 64'd9);
    do_op(2'd0, waddr(0), '0);
    check("R6 oldest clean word evicted", 64'(get_cnt - g0), 64'd10);
  endtask

  task automatic t_offset();
    int g0;
    do_reset();
    do_op(2'd1, waddr(3), '0);
    g0 = get_cnt;
    do_op(2'd1, waddr(3) + 7, '0);
    do_op(2'd2, waddr(3) + 4, 64'd100);
    do_op(2'd0, waddr(3) + 1, '0);
    check("R10 byte offsets share slot", 64'(get_cnt - g0), 64'd0);
    check("R10 accumulated value", rsp_data, init_val(35) + 64'd102);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_miss();
    t_hit_latency();
    t_ops();
    t_capacity();
    t_lru_dirty();
    t_clean();
    t_offset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule